// File: doc/BRIEF.md
# Instruction Address Sequencer with Condition Branch

This block keeps the next-instruction address and the two-bit condition code of a processor status word. Each time an instruction is fetched, the fetch side presents a two-bit length code and the address steps forward by 2, 4 or 6 bytes. A result port writes a new condition code. A conditional-branch port carries a four-bit selection mask and a target address. When the mask bit picked by the current condition code is set, the target replaces the address.

The address register is 31 bits wide. An addressing-mode input chooses which width is active. When it is low, all address arithmetic wraps modulo 2^24 and bits 30..24 stay zero. When it is high, the full 31 bits are in use and arithmetic wraps modulo 2^31. Instructions are halfword aligned, so the address never has bit 0 set. A reserved length code raises a one-cycle error pulse and does not move the address.

Top module: `iaddr_seq`

## Requirements
- R1: After reset, `ia` is 0, `cc` is 0 and `len_err` is 0.
- R2: When `fetch_valid` is high and no branch is taken, `ia` grows by the encoded length on the next clock: code 0 adds 2, code 1 adds 4, code 2 adds 6.
- R3: A fetch with length code 3 sets `len_err` high for exactly the next cycle and leaves `ia` unchanged. `len_err` is low in every other cycle.
- R4: When `cc_valid` is high, `cc` takes `cc_in` on the next clock. The codes are 0 for equal or zero, 1 for low, 2 for high and 3 for overflow or special. Otherwise `cc` holds.
- R5: A branch request is taken when `br_mask[3-cc]` is 1. So mask bit 3 selects code 0 and mask bit 0 selects code 3. A taken branch loads the target into `ia` on the next clock. A mask of 0000 never branches and a mask of 1111 always branches.
- R6: A branch that is not taken has no effect: `ia` holds, or advances if a fetch is present in the same cycle.
- R7: A taken branch wins over a fetch advance in the same cycle. The branch decision uses the condition code held before any update made in that same cycle.
- R8: A loaded branch target has bit 0 forced to 0 and is masked to the active address width.
- R9: Address arithmetic wraps modulo 2^24 when `mode_wide` is 0 and modulo 2^31 when it is 1.
- R10: One cycle after `mode_wide` is seen low, `ia[30:24]` is zero. This applies even when no fetch or branch occurs.
- R11: `ia[0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wide | input | 1 | 1 selects 31-bit addressing, 0 selects 24-bit |
| fetch_valid | input | 1 | An instruction was fetched this cycle |
| fetch_len | input | 2 | Length code of the fetched instruction |
| cc_valid | input | 1 | Load a new condition code |
| cc_in | input | 2 | New condition code |
| br_valid | input | 1 | Conditional branch request |
| br_mask | input | 4 | Condition selection mask |
| br_target | input | 31 | Branch target address |
| ia | output | 31 | Current instruction address |
| cc | output | 2 | Current condition code |
| len_err | output | 1 | One-cycle pulse after a reserved length code |

## Verification
The bench applies every mask value against every condition code. If the mask bit order were reversed, wrong branches would be taken under one of these pairs. It also drives a same-cycle condition-code update alongside a branch, which exposes a design that decides on the new code instead of the old one. The wrap cases step an address across 2^24 and 2^31. A design that ignored the mode would land above the 24-bit range, and one that saturated would stick at the top. A reserved length code and a narrowing of the mode with no other activity check that the error pulse lasts one cycle and that the address is re-masked even when idle.

// File: rtl/iaddr_seq.sv
module iaddr_seq #(
  parameter int AW          = 31,
  parameter int NAW         = 24,
  parameter logic [30:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wide,
  input  logic          fetch_valid,
  input  logic [1:0]    fetch_len,
  input  logic          cc_valid,
  input  logic [1:0]    cc_in,
  input  logic          br_valid,
  input  logic [3:0]    br_mask,
  input  logic [AW-1:0] br_target,
  output logic [AW-1:0] ia,
  output logic [1:0]    cc,
  output logic          len_err
);
  localparam logic [AW-1:0] WIDE_MASK   = {AW{1'b1}};
  localparam logic [AW-1:0] NARROW_MASK = {{(AW-NAW){1'b0}}, {NAW{1'b1}}};

  logic [AW-1:0] amask, step, next_raw, next_ia;
  logic          taken, len_ok;

  assign amask  = mode_wide ? WIDE_MASK : NARROW_MASK;
  assign taken  = br_valid & br_mask[~cc];
  assign len_ok = fetch_valid & (fetch_len != 2'b11);
  assign step   = AW'({fetch_len, 1'b0}) + AW'(2);

  always_comb begin
    if (taken)       next_raw = br_target;
    else if (len_ok) next_raw = ia + step;
    else             next_raw = ia;
  end

  assign next_ia = next_raw & amask & ~AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ia      <= RESET_ADDR & ~AW'(1);
      cc      <= 2'd0;
      len_err <= 1'b0;
    end else begin
      ia      <= next_ia;
      len_err <= fetch_valid & (fetch_len == 2'b11);
      if (cc_valid) cc <= cc_in;
    end
  end
endmodule

module iaddr_seq_chk #(
  parameter int AW  = 31,
  parameter int NAW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_wide,
  input logic          fetch_valid,
  input logic [1:0]    fetch_len,
  input logic          cc_valid,
  input logic [1:0]    cc_in,
  input logic          br_valid,
  input logic [3:0]    br_mask,
  input logic [AW-1:0] ia,
  input logic [1:0]    cc,
  input logic          len_err
);
  p_len_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_len == 2'b11 |=> len_err);
  p_len_err_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && fetch_len == 2'b11) |=> !len_err);
  p_reserved_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_len == 2'b11 && !br_valid && mode_wide |=> $stable(ia));
  p_cc_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid |=> cc == $past(cc_in));
  p_cc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_valid |=> $stable(cc));
  p_mask_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_mask == 4'b0000 && !fetch_valid && mode_wide |=> $stable(ia));
  p_narrow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wide |=> ia[AW-1:NAW] == '0);
  p_align_r11: assert property (@(posedge clk) disable iff (!rst_n) ia[0] == 1'b0);
endmodule

bind iaddr_seq iaddr_seq_chk #(.AW(AW), .NAW(NAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .fetch_valid(fetch_valid),
  .fetch_len(fetch_len), .cc_valid(cc_valid), .cc_in(cc_in), .br_valid(br_valid),
  .br_mask(br_mask), .ia(ia), .cc(cc), .len_err(len_err)
);

// File: tb/iaddr_seq_tb.sv
module iaddr_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic mode_wide = 1, fetch_valid = 0, cc_valid = 0, br_valid = 0;
  logic [1:0] fetch_len = 0, cc_in = 0;
  logic [3:0] br_mask = 0;
  logic [30:0] br_target = 0;
  logic [30:0] ia;
  logic [1:0] cc;
  logic len_err;

  int checks = 0, errors = 0;
  bit done = 0;
  longint ea = 0;
  int ecc = 0;
  bit elerr = 0;

  iaddr_seq u_dut (.clk, .rst_n, .mode_wide, .fetch_valid, .fetch_len, .cc_valid,
    .cc_in, .br_valid, .br_mask, .br_target, .ia, .cc, .len_err);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit mw, bit fv, int len, bit cv, int ccin,
                      bit bv, int mask, longint tgt);
    longint md;
    bit tk;
    @(negedge clk);
    mode_wide = mw; fetch_valid = fv; fetch_len = 2'(len); cc_valid = cv;
    cc_in = 2'(ccin); br_valid = bv; br_mask = 4'(mask); br_target = 31'(tgt);
    md = mw ? (64'd1 << 31) : (64'd1 << 24);
    tk = bv && ((mask >> (3 - ecc)) & 1);
    if (tk) ea = (tgt & ~64'd1) % md;
    else if (fv && len != 3) ea = (ea + 2 * (len + 1)) % md;
    else ea = ea % md;
    if (cv) ecc = ccin;
    elerr = fv && len == 3;
    @(negedge clk);
    chk(req, "ia", ia, ea);
    chk(req, "cc", cc, ecc);
    chk(req, "len_err", len_err, elerr);
    fetch_valid = 0; cc_valid = 0; br_valid = 0;
  endtask

  task automatic idle(string req, bit mw);
    step(req, mw, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ia", ia, 0);
    chk("R1", "cc", cc, 0);
    chk("R1", "len_err", len_err, 0);
    rst_n = 1;
    idle("R1", 1);

    step("R5", 1, 0, 0, 0, 0, 1, 4'hF, 'h100);
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < 2; r++) step("R2", 1, 1, k, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 3, 0, 0, 0, 0, 0);
    idle("R3", 1);
    step("R3", 1, 1, 3, 0, 0, 1, 0, 'h555);

    for (int c = 0; c < 4; c++) begin
      step("R4", 1, 0, 0, 1, c, 0, 0, 0);
      for (int m = 0; m < 16; m++) begin
        step("R5", 1, 0, 0, 0, 0, 1, 4'hF, 'h1000);
        step("R6", 1, 1, 1, 0, 0, 1, m, 'h2222);
        step("R5", 1, 0, 0, 0, 0, 1, m, 'h3330);
        step("R7", 1, 1, 2, 1, 3 - c, 1, m, 'h4440);
        step("R7", 1, 0, 0, 1, c, 0, 0, 0);
      end
    end

    step("R8", 1, 0, 0, 0, 0, 1, 4'hF, 'h7FFF_FFFF);
    step("R8", 0, 0, 0, 0, 0, 1, 4'hF, 'h7FFF_FFFF);
    step("R9", 0, 0, 0, 0, 0, 1, 4'hF, 'hFF_FFFE);
    step("R9", 0, 1, 2, 0, 0, 0, 0, 0);
    step("R9", 1, 0, 0, 0, 0, 1, 4'hF, 'h7FFF_FFFC);
    step("R9", 1, 1, 2, 0, 0, 0, 0, 0);
    step("R10", 1, 0, 0, 0, 0, 1, 4'hF, 'h1234_5678);
    idle("R10", 0);
    chk("R11", "ia bit0", ia[0], 0);
    step("R11", 1, 0, 0, 0, 0, 1, 4'hF, 'h0F0F_0F0F);
    chk("R11", "ia bit0", ia[0], 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule